// File: doc/BRIEF.md
# Register Renamer with Free List

This block maps the architectural registers of one instruction per request onto physical registers. Source operands are looked up in an architectural-to-physical map table, and each one comes back with a ready flag read from a per-physical-register scoreboard. The destination operand takes a fresh physical register from the head of a free-list FIFO. The block then points the map entry at that register and clears the register's scoreboard bit. It returns both the newly assigned register and the one that was mapped before, so that a history tracker can later undo the rename.

If no free register is left, the request is still answered, but it is flagged as blocked and leaves no trace in any state. A rollback block uses two side ports: one writes a chosen physical register into a map entry, the other pushes a physical register onto the tail of the free list. A third side port sets a scoreboard bit when a result is produced.

Top module: `reg_renamer`

## Requirements
- R1: After reset, architectural register i maps to physical register i. The free list holds physical registers NUM_ARCH up to NUM_PHYS-1, and they are handed out in ascending order. Every scoreboard bit is set (ready).
- R2: `req_ready` is high from the first clock edge after reset. Every accepted request (`req_valid` and `req_ready`) produces exactly one `rsp_valid` pulse on the following cycle, and no other cycle has `rsp_valid`.
- R3: Each source returns the physical register that its map entry held just before the accepting edge. Its ready flag is that register's scoreboard bit just before the same edge. Writes made at that edge are not forwarded to the sources.
- R4: An accepted request with `dst_valid`=1 and at least one free register is given the free-list head as `dst_new_phys`. The map entry's prior value is returned as `dst_old_phys`, and the map entry then holds the new register.
- R5: The scoreboard bit of a newly allocated register reads 0 (not ready) after the rename.
- R6: If the free count just before the edge is smaller than the destination count (0 free, one destination), the response has `rsp_blocked`=1 and `dst_new_phys`=`dst_old_phys`=0. The map, the free list and the scoreboard are left as they were.
- R7: `set_en` writes `set_phys` into map entry `set_arch`. If a rename writes the same entry at the same edge, the rename value wins.
- R8: `ret_en` appends `ret_phys` to the free-list tail. A return and an allocation at the same edge both take effect. A return at an edge where the list is empty does not make that register available to a rename at the same edge.
- R9: `wake_en` sets the scoreboard bit of `wake_phys`. If the same register is allocated at the same edge, it ends up not ready.
- R10: A request with `dst_valid`=0 is never blocked, allocates nothing and reports `dst_new_phys`=`dst_old_phys`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Rename request present |
| req_ready | output | 1 | Block accepts requests |
| src0_arch | input | AW | First source architectural register |
| src1_arch | input | AW | Second source architectural register |
| dst_valid | input | 1 | Request carries a destination |
| dst_arch | input | AW | Destination architectural register |
| rsp_valid | output | 1 | Response for the request accepted one cycle earlier |
| rsp_blocked | output | 1 | Request refused for lack of free registers |
| src0_phys | output | PW | First source physical register |
| src0_rdy | output | 1 | First source ready |
| src1_phys | output | PW | Second source physical register |
| src1_rdy | output | 1 | Second source ready |
| dst_new_phys | output | PW | Newly allocated physical register |
| dst_old_phys | output | PW | Previously mapped physical register |
| set_en | input | 1 | Map restore strobe |
| set_arch | input | AW | Map entry to restore |
| set_phys | input | PW | Physical register to write |
| ret_en | input | 1 | Free-list return strobe |
| ret_phys | input | PW | Physical register to return |
| wake_en | input | 1 | Scoreboard set strobe |
| wake_phys | input | PW | Physical register to mark ready |

## Verification
All response fields are registered, so they are due on the first rising edge after the accepting edge. The bench drives inputs on the falling edge and checks outputs on the next falling edge. It compares them with a reference model of map, queue and scoreboard, which it advances by the requirement rules at the same edge. Side-port effects (R5, R7, R8, R9) are therefore visible only one request later. The bench reads them back through a following source lookup or allocation, never in the cycle of the write.

// File: rtl/rr_pkg.sv
package rr_pkg;
  localparam int unsigned RR_ARCH_REGS = 8;
  localparam int unsigned RR_PHYS_REGS = 16;

  function automatic int unsigned rr_idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rr_free_list.sv
module rr_free_list
  import rr_pkg::*;
#(
  parameter int unsigned NUM_ARCH = RR_ARCH_REGS,
  parameter int unsigned NUM_PHYS = RR_PHYS_REGS,
  localparam int unsigned PW   = rr_idx_w(NUM_PHYS),
  localparam int unsigned DEPTH = NUM_PHYS - NUM_ARCH,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop_i,
  input  logic          push_i,
  input  logic [PW-1:0] push_id_i,
  output logic [PW-1:0] head_id_o,
  output logic [CW-1:0] count_o
);
  localparam int unsigned QW = rr_idx_w(DEPTH);

  logic [PW-1:0] slot_q [DEPTH];
  logic [QW-1:0] head_q, head_d, tail_q, tail_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    if (pop_i)  head_d = (head_q == QW'(DEPTH - 1)) ? '0 : head_q + 1'b1;
    if (push_i) tail_d = (tail_q == QW'(DEPTH - 1)) ? '0 : tail_q + 1'b1;
    if (pop_i && !push_i) cnt_d = cnt_q - 1'b1;
    if (push_i && !pop_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= CW'(DEPTH);
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  slot_q[g] <= PW'(NUM_ARCH + g);
      else if (push_i && tail_q == QW'(g))         slot_q[g] <= push_id_i;
    end
  end

  assign head_id_o = slot_q[head_q];
  assign count_o   = cnt_q;

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> (cnt_q != '0));
  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i) |-> (cnt_q != CW'(DEPTH)));
  // R8
  count_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i) |=> $stable(cnt_q));
endmodule

// File: rtl/rr_map_table.sv
module rr_map_table
  import rr_pkg::*;
#(
  parameter int unsigned NUM_ARCH = RR_ARCH_REGS,
  parameter int unsigned NUM_PHYS = RR_PHYS_REGS,
  localparam int unsigned AW = rr_idx_w(NUM_ARCH),
  localparam int unsigned PW = rr_idx_w(NUM_PHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd0_arch_i,
  input  logic [AW-1:0] rd1_arch_i,
  input  logic [AW-1:0] rd2_arch_i,
  output logic [PW-1:0] rd0_phys_o,
  output logic [PW-1:0] rd1_phys_o,
  output logic [PW-1:0] rd2_phys_o,
  input  logic          set_en_i,
  input  logic [AW-1:0] set_arch_i,
  input  logic [PW-1:0] set_phys_i,
  input  logic          ren_en_i,
  input  logic [AW-1:0] ren_arch_i,
  input  logic [PW-1:0] ren_phys_i
);
  logic [PW-1:0] map_q [NUM_ARCH];

  for (genvar g = 0; g < NUM_ARCH; g++) begin : g_ent
    logic          we;
    logic [PW-1:0] wd;
    always_comb begin
      we = 1'b0;
      wd = map_q[g];
      if (set_en_i && set_arch_i == AW'(g)) begin
        we = 1'b1;
        wd = set_phys_i;
      end
      if (ren_en_i && ren_arch_i == AW'(g)) begin
        we = 1'b1;
        wd = ren_phys_i;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  map_q[g] <= PW'(g);
      else if (we) map_q[g] <= wd;
    end
  end

  assign rd0_phys_o = map_q[rd0_arch_i];
  assign rd1_phys_o = map_q[rd1_arch_i];
  assign rd2_phys_o = map_q[rd2_arch_i];

  // R7
  ren_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ren_en_i |=> (map_q[$past(ren_arch_i)] == $past(ren_phys_i)));
endmodule

// File: rtl/rr_scoreboard.sv
module rr_scoreboard
  import rr_pkg::*;
#(
  parameter int unsigned NUM_PHYS = RR_PHYS_REGS,
  localparam int unsigned PW = rr_idx_w(NUM_PHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] rd0_i,
  input  logic [PW-1:0] rd1_i,
  output logic          rdy0_o,
  output logic          rdy1_o,
  input  logic          set_en_i,
  input  logic [PW-1:0] set_idx_i,
  input  logic          clr_en_i,
  input  logic [PW-1:0] clr_idx_i
);
  logic [NUM_PHYS-1:0] bits_q, bits_d;

  always_comb begin
    bits_d = bits_q;
    if (set_en_i) bits_d[set_idx_i] = 1'b1;
    if (clr_en_i) bits_d[clr_idx_i] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits_q <= '1;
    else        bits_q <= bits_d;
  end

  assign rdy0_o = bits_q[rd0_i];
  assign rdy1_o = bits_q[rd1_i];

  // R5
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en_i |=> !bits_q[$past(clr_idx_i)]);
  // R9
  wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en_i && !(clr_en_i && clr_idx_i == set_idx_i)) |=> bits_q[$past(set_idx_i)]);
endmodule

// File: rtl/reg_renamer.sv
module reg_renamer
  import rr_pkg::*;
#(
  parameter int unsigned NUM_ARCH = RR_ARCH_REGS,
  parameter int unsigned NUM_PHYS = RR_PHYS_REGS,
  localparam int unsigned AW = rr_idx_w(NUM_ARCH),
  localparam int unsigned PW = rr_idx_w(NUM_PHYS),
  localparam int unsigned CW = $clog2(NUM_PHYS - NUM_ARCH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] src0_arch,
  input  logic [AW-1:0] src1_arch,
  input  logic          dst_valid,
  input  logic [AW-1:0] dst_arch,
  output logic          rsp_valid,
  output logic          rsp_blocked,
  output logic [PW-1:0] src0_phys,
  output logic          src0_rdy,
  output logic [PW-1:0] src1_phys,
  output logic          src1_rdy,
  output logic [PW-1:0] dst_new_phys,
  output logic [PW-1:0] dst_old_phys,
  input  logic          set_en,
  input  logic [AW-1:0] set_arch,
  input  logic [PW-1:0] set_phys,
  input  logic          ret_en,
  input  logic [PW-1:0] ret_phys,
  input  logic          wake_en,
  input  logic [PW-1:0] wake_phys
);
  logic          ready_q;
  logic          take, alloc, refuse;
  logic [PW-1:0] head_id, s0_p, s1_p, d_old;
  logic          s0_r, s1_r;
  logic [CW-1:0] free_cnt;

  assign take   = req_valid && ready_q;
  assign alloc  = take && dst_valid && (free_cnt != '0);
  assign refuse = take && dst_valid && (free_cnt == '0);

  rr_free_list #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) free_i (
    .clk(clk), .rst_n(rst_n), .pop_i(alloc), .push_i(ret_en),
    .push_id_i(ret_phys), .head_id_o(head_id), .count_o(free_cnt));

  rr_map_table #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) map_i (
    .clk(clk), .rst_n(rst_n),
    .rd0_arch_i(src0_arch), .rd1_arch_i(src1_arch), .rd2_arch_i(dst_arch),
    .rd0_phys_o(s0_p), .rd1_phys_o(s1_p), .rd2_phys_o(d_old),
    .set_en_i(set_en), .set_arch_i(set_arch), .set_phys_i(set_phys),
    .ren_en_i(alloc), .ren_arch_i(dst_arch), .ren_phys_i(head_id));

  rr_scoreboard #(.NUM_PHYS(NUM_PHYS)) sb_i (
    .clk(clk), .rst_n(rst_n), .rd0_i(s0_p), .rd1_i(s1_p),
    .rdy0_o(s0_r), .rdy1_o(s1_r),
    .set_en_i(wake_en), .set_idx_i(wake_phys),
    .clr_en_i(alloc), .clr_idx_i(head_id));

  logic          vld_d, blk_d, r0_d, r1_d;
  logic [PW-1:0] p0_d, p1_d, nw_d, od_d;

  always_comb begin
    vld_d = take;
    blk_d = refuse;
    p0_d  = s0_p;
    p1_d  = s1_p;
    r0_d  = s0_r;
    r1_d  = s1_r;
    nw_d  = alloc ? head_id : '0;
    od_d  = alloc ? d_old   : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q   <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      ready_q   <= 1'b1;
      rsp_valid <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_blocked  <= 1'b0;
      src0_phys    <= '0;
      src1_phys    <= '0;
      src0_rdy     <= 1'b0;
      src1_rdy     <= 1'b0;
      dst_new_phys <= '0;
      dst_old_phys <= '0;
    end else if (take) begin
      rsp_blocked  <= blk_d;
      src0_phys    <= p0_d;
      src1_phys    <= p1_d;
      src0_rdy     <= r0_d;
      src1_rdy     <= r1_d;
      dst_new_phys <= nw_d;
      dst_old_phys <= od_d;
    end
  end

  assign req_ready = ready_q;

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
  // R2
  rsp_only_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !rsp_valid);
  // R6
  blocked_no_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_blocked) |-> (dst_new_phys == '0 && dst_old_phys == '0));
  // R6
  blocked_keeps_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (refuse && !ret_en) |=> $stable(free_cnt));
endmodule

// File: tb/reg_renamer_tb_top.sv
module reg_renamer_tb_top;
  localparam int NA = 8;
  localparam int NP = 16;
  localparam int AW = 3;
  localparam int PW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          req_valid = 0, dst_valid = 0, set_en = 0, ret_en = 0, wake_en = 0;
  logic [AW-1:0] src0_arch = 0, src1_arch = 0, dst_arch = 0, set_arch = 0;
  logic [PW-1:0] set_phys = 0, ret_phys = 0, wake_phys = 0;
  logic          req_ready, rsp_valid, rsp_blocked, src0_rdy, src1_rdy;
  logic [PW-1:0] src0_phys, src1_phys, dst_new_phys, dst_old_phys;

  reg_renamer dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .src0_arch(src0_arch), .src1_arch(src1_arch), .dst_valid(dst_valid),
    .dst_arch(dst_arch), .rsp_valid(rsp_valid), .rsp_blocked(rsp_blocked),
    .src0_phys(src0_phys), .src0_rdy(src0_rdy), .src1_phys(src1_phys),
    .src1_rdy(src1_rdy), .dst_new_phys(dst_new_phys), .dst_old_phys(dst_old_phys),
    .set_en(set_en), .set_arch(set_arch), .set_phys(set_phys),
    .ret_en(ret_en), .ret_phys(ret_phys), .wake_en(wake_en), .wake_phys(wake_phys));

  int n_chk = 0;
  int n_bad = 0;
  int map_m [NA];
  bit sb_m  [NP];
  int fl_m [$];

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one request cycle: inputs already set, called at a falling edge
  task automatic cycle(input string tag);
    int e0, e1, r0, r1, nw, od, blk;
    bit alloc;
    e0 = map_m[src0_arch]; e1 = map_m[src1_arch];
    r0 = sb_m[e0]; r1 = sb_m[e1];
    alloc = req_valid && dst_valid && fl_m.size() > 0;
    blk   = (req_valid && dst_valid && fl_m.size() == 0) ? 1 : 0;
    nw = alloc ? fl_m[0] : 0;
    od = alloc ? map_m[dst_arch] : 0;
    if (set_en) map_m[set_arch] = set_phys;
    if (alloc) begin
      map_m[dst_arch] = nw;
      void'(fl_m.pop_front());
    end
    if (wake_en) sb_m[wake_phys] = 1'b1;
    if (alloc) sb_m[nw] = 1'b0;
    if (ret_en) fl_m.push_back(int'(ret_phys));
    @(posedge clk);
    @(negedge clk);
    chk({tag, " R2 rsp_valid"}, rsp_valid, req_valid);
    if (req_valid) begin
      chk({tag, " R3 src0_phys"}, src0_phys, e0);
      chk({tag, " R3 src1_phys"}, src1_phys, e1);
      chk({tag, " R3 src0_rdy"}, src0_rdy, r0);
      chk({tag, " R3 src1_rdy"}, src1_rdy, r1);
      chk({tag, " R6 rsp_blocked"}, rsp_blocked, blk);
      chk({tag, " R4 dst_new_phys"}, dst_new_phys, nw);
      chk({tag, " R4 dst_old_phys"}, dst_old_phys, od);
    end
    req_valid = 0; dst_valid = 0; set_en = 0; ret_en = 0; wake_en = 0;
  endtask

  task automatic lookup(input int a, input int b, input string tag);
    req_valid = 1; src0_arch = AW'(a); src1_arch = AW'(b);
    cycle(tag);
  endtask

  task automatic rename(input int d, input string tag);
    req_valid = 1; dst_valid = 1; dst_arch = AW'(d);
    src0_arch = AW'(d); src1_arch = AW'((d + 1) % NA);
    cycle(tag);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < NA; i++) map_m[i] = i;
    for (int i = 0; i < NP; i++) sb_m[i] = 1'b1;
    for (int i = NA; i < NP; i++) fl_m.push_back(i);
    repeat (2) @(negedge clk);
    chk("R2 rsp_valid in reset", rsp_valid, 0);
    chk("R2 req_ready in reset", req_ready, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R2 req_ready after reset", req_ready, 1);
    chk("R2 idle rsp_valid", rsp_valid, 0);

    // R1 R3 R10: identity map and all-ready scoreboard, every source pair
    for (int a = 0; a < NA; a++)
      for (int b = 0; b < NA; b++) lookup(a, b, "R1 R10 sweep");

    // R1 R4 R5: drain the list in ascending order
    for (int k = 0; k < NA; k++) rename(k, "R1 R4 drain");
    for (int a = 0; a < NA; a++) lookup(a, (a + 3) % NA, "R5 after drain");

    // R6: empty list refuses; return in same cycle does not help
    rename(3, "R6 empty");
    ret_en = 1; ret_phys = 5;
    rename(4, "R6 R8 empty with return");
    rename(2, "R8 returned reg");
    lookup(2, 4, "R6 state kept");

    // R8: simultaneous pop and push
    ret_en = 1; ret_phys = 0; lookup(0, 1, "R8 push");
    ret_en = 1; ret_phys = 1; lookup(0, 1, "R8 push");
    ret_en = 1; ret_phys = 2; rename(4, "R8 pop and push");
    rename(5, "R8 order");
    rename(6, "R8 order");
    rename(7, "R6 empty again");

    // R7: restore port, and rename winning on the same entry
    ret_en = 1; ret_phys = 3; lookup(0, 0, "R8 push");
    set_en = 1; set_arch = 6; set_phys = 6; rename(6, "R7 collide");
    lookup(6, 6, "R7 rename wins");
    set_en = 1; set_arch = 7; set_phys = 7; lookup(7, 6, "R7 not forwarded");
    lookup(7, 6, "R7 restored");

    // R9: wake every register, then read all sources
    for (int p = 0; p < NP; p++) begin
      wake_en = 1; wake_phys = PW'(p); lookup(p % NA, (p + 1) % NA, "R9 wake");
    end
    for (int a = 0; a < NA; a++) lookup(a, a, "R9 after wake");

    // R9 R5: wake and allocate same register, clear wins
    ret_en = 1; ret_phys = 9; lookup(0, 0, "R8 push");
    wake_en = 1; wake_phys = 4'(fl_m[0]); rename(0, "R9 collide");
    lookup(0, 1, "R9 clear wins");

    // mixed traffic from an LFSR
    begin
      logic [15:0] lf;
      lf = 16'hACE1;
      for (int t = 0; t < 600; t++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        req_valid = lf[0];
        dst_valid = lf[1];
        src0_arch = lf[4:2]; src1_arch = lf[7:5]; dst_arch = lf[10:8];
        set_en = lf[11] & lf[12]; set_arch = lf[14:12]; set_phys = lf[3:0];
        ret_en = lf[13] && (fl_m.size() < (NP - NA) ||
                 (req_valid && dst_valid && fl_m.size() > 0));
        ret_phys = lf[9:6];
        wake_en = lf[15]; wake_phys = lf[5:2];
        cycle("R3 R4 R8 mixed");
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule